// File: doc/BRIEF.md
# SWD register access engine

This block turns register-level debug commands into packet transfers on a serial wire debug link. A command names either the debug port or an access port, gives read or write, a register address and, for writes, a data word. A lower packet engine carries out each transfer and returns a 3-bit acknowledge and read data. This block decides how many transfers a command needs and in what order they run.

The block keeps shadow copies of the bank-select word and of the access port's control/status word, and it skips writes that would not change them. Before each access-port transfer it points the bank select at the correct port and bank. It also hides the pipelined nature of access-port reads by issuing each read twice. After an access-port write it confirms the write with a read of the read-buffer register. A transfer that returns WAIT is issued again, up to a parameterised number of attempts.

Top module: `swd_reg_engine`

## Requirements
- R1: A transfer whose acknowledge is WAIT (3'b010) is issued again with identical fields, up to MAX_TRIES (default 100) attempts in total. When the limit is reached, WAIT is reported as the final acknowledge.
- R2: Any acknowledge other than WAIT ends that transfer's retries at once.
- R3: A command reports `rsp_ack` equal to the acknowledge of its deciding transfer, and `rsp_err` is high exactly when that value is not OK (3'b001). FAULT is 3'b100.
- R4: A debug-port write to the bank-select register (register index 2, from `cmd_addr[3:2]`) whose data equals the shadow copy completes with OK and issues no transfer.
- R5: The bank-select shadow takes a new value only when a bank-select write returns OK. A failed write leaves the shadow as it was.
- R6: Each access-port command first needs bank select equal to {`cmd_apsel`, 16'h0, `cmd_addr[7:4]`, 4'h0}. This write is skipped under R4. If it fails, the command ends with its acknowledge and no access-port transfer runs.
- R7: An access-port read issues the same read transfer twice. The second transfer's acknowledge and data are returned, and the first transfer's acknowledge and data are ignored.
- R8: After an access-port write returns OK, a debug-port read of register index 3 (read buffer) follows, and its acknowledge decides the result. A failed access-port write issues no read-buffer read.
- R9: An access-port write to address 8'h00 (control/status) with data equal to its shadow completes with OK and issues no transfer. Otherwise the shadow takes the data when that write is issued.
- R10: Reset, and a one-cycle `init` pulse, set both shadows to 32'hFFFF_FFFF. The next write of a previously cached value therefore goes out on the link.
- R11: `cmd_ready` is high only while idle. Each accepted command yields exactly one single-cycle `rsp_done`.
- R12: `pkt_req` stays high with stable fields until `pkt_gnt`. Read data is returned on `rsp_rdata` for read commands and is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Invalidate both shadow copies |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and accepting |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_apsel | input | 8 | Access port number |
| cmd_addr | input | 8 | Register address; [7:4] bank, [3:2] register |
| cmd_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Command finished (one cycle) |
| rsp_err | output | 1 | Final acknowledge not OK, valid with done |
| rsp_ack | output | 3 | Final acknowledge |
| rsp_rdata | output | 32 | Read result |
| pkt_req | output | 1 | Transfer request to packet engine |
| pkt_ap | output | 1 | Transfer targets access port |
| pkt_write | output | 1 | Transfer is a write |
| pkt_reg | output | 2 | Transfer register index |
| pkt_wdata | output | 32 | Transfer write data |
| pkt_gnt | input | 1 | Packet engine finished the transfer (one cycle) |
| pkt_ack | input | 3 | Acknowledge, valid with grant |
| pkt_rdata | input | 32 | Read data, valid with grant |

## Verification
The properties assume the packet engine grants only while a request is up, with a single-cycle grant, and that commands are offered only through the valid/ready handshake. The scripted packet-engine model in the bench answers each raised request once, one cycle after it appears, and then drops the grant. It never grants spontaneously. The bench pulses `init` only between commands, because the shadows are not meant to be cleared in the middle of a sequence.

// File: rtl/swd_acc_pkg.sv
package swd_acc_pkg;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] DP_IDX_BANKSEL = 2'd2;
    localparam logic [1:0] DP_IDX_RDBUF   = 2'd3;
    localparam logic [7:0] AP_ADDR_CTRL   = 8'h00;
    localparam logic [31:0] SHADOW_VOID   = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        ap;
        logic        write;
        logic [1:0]  idx;
        logic [31:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic        ap;
        logic        write;
        logic [7:0]  apsel;
        logic [7:0]  addr;
        logic [31:0] wdata;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_DISPATCH, S_BANKWAIT, S_APSTEP,
        S_APWWAIT, S_RDBWAIT, S_APR1, S_APR2
    } seq_state_e;

    localparam int S_DPWAIT_ALIAS = 0;

    function automatic logic [31:0] bank_word(input logic [7:0] apsel, input logic [7:0] addr);
        return {apsel, 16'h0000, addr[7:4], 4'h0};
    endfunction

endpackage

// File: rtl/swd_shadow_regs.sv
module swd_shadow_regs
    import swd_acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        sel_upd,
    input  logic [31:0] sel_upd_val,
    input  logic        ctl_upd,
    input  logic [31:0] ctl_upd_val,
    output logic [31:0] sel_shadow,
    output logic [31:0] ctl_shadow
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            sel_shadow <= SHADOW_VOID;
            ctl_shadow <= SHADOW_VOID;
        end else begin
            if (sel_upd) sel_shadow <= sel_upd_val;
            if (ctl_upd) ctl_shadow <= ctl_upd_val;
        end
    end

endmodule

// File: rtl/swd_retry_unit.sv
module swd_retry_unit
    import swd_acc_pkg::*;
#(
    parameter int MAX_TRIES = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  xfer_t       xf_in,
    output logic        done,
    output logic [2:0]  ack,
    output logic [31:0] rdata,
    output logic        pkt_req,
    output xfer_t       pkt_xf,
    input  logic        pkt_gnt,
    input  logic [2:0]  pkt_ack,
    input  logic [31:0] pkt_rdata
);

    localparam int CW = $clog2(MAX_TRIES + 1);

    logic          busy;
    logic [CW-1:0] tries;

    assign pkt_req = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            tries  <= '0;
            ack    <= '0;
            rdata  <= '0;
            pkt_xf <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && go) begin
                busy   <= 1'b1;
                pkt_xf <= xf_in;
                tries  <= CW'(1);
            end else if (busy && pkt_gnt) begin
                if (pkt_ack == ACK_WAIT && tries < CW'(MAX_TRIES)) begin
                    tries <= tries + CW'(1);
                end else begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    ack   <= pkt_ack;
                    rdata <= pkt_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/swd_cmd_seq.sv
module swd_cmd_seq
    import swd_acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  cmd_t        cmd_in,
    input  logic [31:0] sel_shadow,
    input  logic [31:0] ctl_shadow,
    output logic        sel_upd,
    output logic [31:0] sel_upd_val,
    output logic        ctl_upd,
    output logic [31:0] ctl_upd_val,
    output logic        xf_go,
    output xfer_t       xf_out,
    input  logic        xf_done,
    input  logic [2:0]  xf_ack,
    input  logic [31:0] xf_rdata,
    output logic        rsp_done,
    output logic [2:0]  rsp_ack,
    output logic [31:0] rsp_rdata
);

    seq_state_e  state;
    logic        dp_wait;
    cmd_t        cq;
    logic [31:0] want_sel;
    logic        is_sel_wr;
    logic        is_ctl_wr;

    assign want_sel  = bank_word(cq.apsel, cq.addr);
    assign is_sel_wr = !cq.ap && cq.write && (cq.addr[3:2] == DP_IDX_BANKSEL);
    assign is_ctl_wr = cq.ap && cq.write && (cq.addr == AP_ADDR_CTRL);
    assign cmd_ready = (state == S_IDLE) && !dp_wait;

    always_comb begin
        sel_upd     = 1'b0;
        sel_upd_val = want_sel;
        if (state == S_BANKWAIT && xf_done && xf_ack == ACK_OK) begin
            sel_upd = 1'b1;
        end
        if (dp_wait && xf_done && is_sel_wr && xf_ack == ACK_OK) begin
            sel_upd     = 1'b1;
            sel_upd_val = cq.wdata;
        end
        ctl_upd     = (state == S_APSTEP) && is_ctl_wr && (cq.wdata != ctl_shadow);
        ctl_upd_val = cq.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            dp_wait   <= 1'b0;
            cq        <= '0;
            xf_go     <= 1'b0;
            xf_out    <= '0;
            rsp_done  <= 1'b0;
            rsp_ack   <= '0;
            rsp_rdata <= '0;
        end else begin
            xf_go    <= 1'b0;
            rsp_done <= 1'b0;
            if (dp_wait) begin
                if (xf_done) begin
                    dp_wait   <= 1'b0;
                    rsp_done  <= 1'b1;
                    rsp_ack   <= xf_ack;
                    rsp_rdata <= cq.write ? 32'h0 : xf_rdata;
                end
            end else begin
                case (state)
                    S_IDLE: begin
                        if (cmd_valid) begin
                            cq    <= cmd_in;
                            state <= S_DISPATCH;
                        end
                    end
                    S_DISPATCH: begin
                        if (cq.ap) begin
                            if (want_sel == sel_shadow) begin
                                state <= S_APSTEP;
                            end else begin
                                xf_go  <= 1'b1;
                                xf_out <= '{ap: 1'b0, write: 1'b1, idx: DP_IDX_BANKSEL, wdata: want_sel};
                                state  <= S_BANKWAIT;
                            end
                        end else if (is_sel_wr && cq.wdata == sel_shadow) begin
                            rsp_done  <= 1'b1;
                            rsp_ack   <= ACK_OK;
                            rsp_rdata <= 32'h0;
                            state     <= S_IDLE;
                        end else begin
                            xf_go   <= 1'b1;
                            xf_out  <= '{ap: 1'b0, write: cq.write, idx: cq.addr[3:2], wdata: cq.wdata};
                            dp_wait <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                    S_BANKWAIT: begin
                        if (xf_done) begin
                            if (xf_ack == ACK_OK) begin
                                state <= S_APSTEP;
                            end else begin
                                rsp_done  <= 1'b1;
                                rsp_ack   <= xf_ack;
                                rsp_rdata <= 32'h0;
                                state     <= S_IDLE;
                            end
                        end
                    end
                    S_APSTEP: begin
                        if (is_ctl_wr && cq.wdata == ctl_shadow) begin
                            rsp_done  <= 1'b1;
                            rsp_ack   <= ACK_OK;
                            rsp_rdata <= 32'h0;
                            state     <= S_IDLE;
                        end else begin
                            xf_go  <= 1'b1;
                            xf_out <= '{ap: 1'b1, write: cq.write, idx: cq.addr[3:2],
                                        wdata: cq.write ? cq.wdata : 32'h0};
                            state  <= cq.write ? S_APWWAIT : S_APR1;
                        end
                    end
                    S_APWWAIT: begin
                        if (xf_done) begin
                            if (xf_ack == ACK_OK) begin
                                xf_go  <= 1'b1;
                                xf_out <= '{ap: 1'b0, write: 1'b0, idx: DP_IDX_RDBUF, wdata: 32'h0};
                                state  <= S_RDBWAIT;
                            end else begin
                                rsp_done  <= 1'b1;
                                rsp_ack   <= xf_ack;
                                rsp_rdata <= 32'h0;
                                state     <= S_IDLE;
                            end
                        end
                    end
                    S_RDBWAIT: begin
                        if (xf_done) begin
                            rsp_done  <= 1'b1;
                            rsp_ack   <= xf_ack;
                            rsp_rdata <= 32'h0;
                            state     <= S_IDLE;
                        end
                    end
                    S_APR1: begin
                        if (xf_done) begin
                            xf_go <= 1'b1;
                            state <= S_APR2;
                        end
                    end
                    S_APR2: begin
                        if (xf_done) begin
                            rsp_done  <= 1'b1;
                            rsp_ack   <= xf_ack;
                            rsp_rdata <= xf_rdata;
                            state     <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/swd_reg_engine.sv
module swd_reg_engine
    import swd_acc_pkg::*;
#(
    parameter int MAX_TRIES = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_ap,
    input  logic        cmd_write,
    input  logic [7:0]  cmd_apsel,
    input  logic [7:0]  cmd_addr,
    input  logic [31:0] cmd_wdata,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [2:0]  rsp_ack,
    output logic [31:0] rsp_rdata,
    output logic        pkt_req,
    output logic        pkt_ap,
    output logic        pkt_write,
    output logic [1:0]  pkt_reg,
    output logic [31:0] pkt_wdata,
    input  logic        pkt_gnt,
    input  logic [2:0]  pkt_ack,
    input  logic [31:0] pkt_rdata
);

    cmd_t        cmd_in;
    logic [31:0] sel_shadow, ctl_shadow;
    logic        sel_upd, ctl_upd;
    logic [31:0] sel_upd_val, ctl_upd_val;
    logic        xf_go, xf_done;
    xfer_t       xf_req, pkt_xf;
    logic [2:0]  xf_ack;
    logic [31:0] xf_rdata;

    assign cmd_in = '{ap: cmd_ap, write: cmd_write, apsel: cmd_apsel,
                      addr: cmd_addr, wdata: cmd_wdata};

    swd_shadow_regs u_shadow (
        .clk, .rst, .init,
        .sel_upd, .sel_upd_val, .ctl_upd, .ctl_upd_val,
        .sel_shadow, .ctl_shadow
    );

    swd_cmd_seq u_seq (
        .clk, .rst, .cmd_valid, .cmd_ready, .cmd_in,
        .sel_shadow, .ctl_shadow,
        .sel_upd, .sel_upd_val, .ctl_upd, .ctl_upd_val,
        .xf_go, .xf_out(xf_req), .xf_done, .xf_ack, .xf_rdata,
        .rsp_done, .rsp_ack, .rsp_rdata
    );

    swd_retry_unit #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk, .rst, .go(xf_go), .xf_in(xf_req),
        .done(xf_done), .ack(xf_ack), .rdata(xf_rdata),
        .pkt_req, .pkt_xf, .pkt_gnt, .pkt_ack, .pkt_rdata
    );

    assign pkt_ap    = pkt_xf.ap;
    assign pkt_write = pkt_xf.write;
    assign pkt_reg   = pkt_xf.idx;
    assign pkt_wdata = pkt_xf.wdata;
    assign rsp_err   = rsp_done && (rsp_ack != ACK_OK);

endmodule

// File: rtl/swd_reg_engine_chk.sv
module swd_reg_engine_chk
    import swd_acc_pkg::*;
#(
    parameter int MAX_TRIES = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        pkt_req,
    input logic        pkt_ap,
    input logic        pkt_write,
    input logic [1:0]  pkt_reg,
    input logic [31:0] pkt_wdata,
    input logic        pkt_gnt,
    input logic [2:0]  pkt_ack,
    input logic        rsp_done
);

    localparam int RW = $clog2(MAX_TRIES + 2) + 1;

    logic [RW-1:0] wait_run;

    always_ff @(posedge clk) begin
        if (rst || !pkt_req) begin
            wait_run <= '0;
        end else if (pkt_gnt) begin
            wait_run <= (pkt_ack == ACK_WAIT) ? wait_run + RW'(1) : '0;
        end
    end

    assert_retry_cap_R1: assert property (@(posedge clk) disable iff (rst)
        wait_run <= RW'(MAX_TRIES));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        pkt_req && !pkt_gnt |=> pkt_req && $stable(pkt_ap) && $stable(pkt_write)
                                && $stable(pkt_reg) && $stable(pkt_wdata));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !pkt_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

endmodule

bind swd_reg_engine swd_reg_engine_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (.*);

// File: tb/tb_swd_reg_engine.sv
module tb_swd_reg_engine;
    import swd_acc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_TRIES  = 100;

    logic        clk = 1'b0;
    logic        rst, init, cmd_valid, cmd_ready, cmd_ap, cmd_write;
    logic [7:0]  cmd_apsel, cmd_addr;
    logic [31:0] cmd_wdata, rsp_rdata, pkt_wdata, pkt_rdata;
    logic        rsp_done, rsp_err, pkt_req, pkt_ap, pkt_write, pkt_gnt;
    logic [2:0]  rsp_ack, pkt_ack;
    logic [1:0]  pkt_reg;

    swd_reg_engine #(.MAX_TRIES(MAX_TRIES)) dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    string cur_tag = "R11";

    typedef struct {
        bit          ap;
        bit          wr;
        logic [1:0]  idx;
        logic [31:0] wd;
    } exp_xf_t;

    exp_xf_t    exp_q[$];
    logic [2:0] dut_script[$];
    logic [2:0] mdl_script[$];
    int         rsp_cnt = 0;
    int         mdl_cnt = 0;
    logic [31:0] m_sel = 32'hFFFF_FFFF;
    logic [31:0] m_ctl = 32'hFFFF_FFFF;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_ack(input logic [2:0] a);
        dut_script.push_back(a);
        mdl_script.push_back(a);
    endtask

    // packet engine model: grants each raised request one cycle later
    initial begin
        pkt_gnt = 1'b0; pkt_ack = 3'b000; pkt_rdata = 32'h0;
        forever begin
            if (pkt_req === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected transfer", {30'h0, pkt_reg}, 32'h0);
                end else begin
                    exp_xf_t e;
                    e = exp_q.pop_front();
                    check(pkt_ap == e.ap && pkt_write == e.wr && pkt_reg == e.idx,
                          cur_tag, "transfer kind", {28'h0, pkt_ap, pkt_write, pkt_reg},
                          {28'h0, e.ap, e.wr, e.idx});
                    if (e.wr) check(pkt_wdata == e.wd, cur_tag, "transfer wdata", pkt_wdata, e.wd);
                end
                @(negedge clk);
                pkt_gnt   = 1'b1;
                pkt_ack   = (dut_script.size() != 0) ? dut_script.pop_front() : ACK_OK;
                pkt_rdata = 32'hD000_0000 + rsp_cnt;
                rsp_cnt++;
                @(negedge clk);
                pkt_gnt = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // behavioural reference: one transfer with its retries
    task automatic m_xfer(input bit ap, input bit wr, input logic [1:0] idx, input logic [31:0] wd,
                          output logic [2:0] ack, output logic [31:0] rd);
        ack = ACK_OK;
        rd  = 32'h0;
        for (int i = 0; i < MAX_TRIES; i++) begin
            ack = (mdl_script.size() != 0) ? mdl_script.pop_front() : ACK_OK;
            exp_q.push_back('{ap, wr, idx, wd});
            rd = 32'hD000_0000 + mdl_cnt;
            mdl_cnt++;
            if (ack != ACK_WAIT) break;
        end
    endtask

    task automatic m_cmd(input bit ap, input bit wr, input logic [7:0] apsel, input logic [7:0] addr,
                         input logic [31:0] wd, output logic [2:0] ack, output logic [31:0] rd);
        logic [31:0] r, sw;
        rd  = 32'h0;
        ack = ACK_OK;
        if (!ap) begin
            if (wr && addr[3:2] == 2'd2 && wd == m_sel) return;
            m_xfer(1'b0, wr, addr[3:2], wd, ack, r);
            if (wr && addr[3:2] == 2'd2 && ack == ACK_OK) m_sel = wd;
            rd = wr ? 32'h0 : r;
            return;
        end
        sw = {apsel, 16'h0, addr[7:4], 4'h0};
        if (sw != m_sel) begin
            m_xfer(1'b0, 1'b1, 2'd2, sw, ack, r);
            if (ack != ACK_OK) return;
            m_sel = sw;
        end
        if (wr) begin
            if (addr == 8'h00) begin
                if (wd == m_ctl) return;
                m_ctl = wd;
            end
            m_xfer(1'b1, 1'b1, addr[3:2], wd, ack, r);
            if (ack != ACK_OK) return;
            m_xfer(1'b0, 1'b0, 2'd3, 32'h0, ack, r);
            return;
        end
        m_xfer(1'b1, 1'b0, addr[3:2], 32'h0, ack, r);
        m_xfer(1'b1, 1'b0, addr[3:2], 32'h0, ack, r);
        rd = r;
    endtask

    task automatic run_cmd(input bit ap, input bit wr, input logic [7:0] apsel, input logic [7:0] addr,
                           input logic [31:0] wd, input string tag);
        logic [2:0]  eack;
        logic [31:0] erd;
        int n;
        cur_tag = tag;
        m_cmd(ap, wr, apsel, addr, wd, eack, erd);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R11", "ready before command", {31'h0, cmd_ready}, 32'h1);
        cmd_ap = ap; cmd_write = wr; cmd_apsel = apsel; cmd_addr = addr; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (rsp_done !== 1'b1 && n < 3000) begin
            check(cmd_ready == 1'b0, "R11", "ready while busy", {31'h0, cmd_ready}, 32'h0);
            @(negedge clk);
            n++;
        end
        check(rsp_done === 1'b1, "R11", "done seen", {31'h0, rsp_done}, 32'h1);
        check(rsp_ack == eack, tag, "final ack", {29'h0, rsp_ack}, {29'h0, eack});
        check(rsp_err == (eack != ACK_OK), "R3", "error flag", {31'h0, rsp_err}, {31'h0, eack != ACK_OK});
        if (!wr) check(rsp_rdata == erd, tag, "read data", rsp_rdata, erd);
        else     check(rsp_rdata == 32'h0, "R12", "write rdata zero", rsp_rdata, 32'h0);
        check(exp_q.size() == 0, tag, "missing transfers", exp_q.size(), 32'h0);
        exp_q.delete();
        @(negedge clk);
        check(rsp_done == 1'b0, "R11", "single done pulse", {31'h0, rsp_done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; init = 1'b0; cmd_valid = 1'b0; cmd_ap = 1'b0; cmd_write = 1'b0;
        cmd_apsel = 8'h0; cmd_addr = 8'h0; cmd_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R11", "reset ready", {31'h0, cmd_ready}, 32'h1);
        check(pkt_req == 1'b0, "R12", "reset request", {31'h0, pkt_req}, 32'h0);
        check(rsp_done == 1'b0, "R11", "reset done", {31'h0, rsp_done}, 32'h0);

        // R10: shadows void after reset, so a zero bank-select write goes out
        run_cmd(1'b0, 1'b1, 8'h00, 8'h08, 32'h0, "R10");
        // R4: same value again is skipped
        run_cmd(1'b0, 1'b1, 8'h00, 8'h08, 32'h0, "R4");
        // R1: two WAITs then OK on a debug read
        push_ack(ACK_WAIT); push_ack(ACK_WAIT); push_ack(ACK_OK);
        run_cmd(1'b0, 1'b0, 8'h00, 8'h04, 32'h0, "R1");
        // R2: WAIT then FAULT stops at once
        push_ack(ACK_WAIT); push_ack(ACK_FAULT);
        run_cmd(1'b0, 1'b0, 8'h00, 8'h04, 32'h0, "R2");
        // R7: access read, bank already selected, doubled transfer
        run_cmd(1'b1, 1'b0, 8'h00, 8'h0C, 32'h0, "R7");
        // R8: control/status write confirmed by read buffer
        run_cmd(1'b1, 1'b1, 8'h00, 8'h00, 32'h2300_0052, "R8");
        // R9: identical control/status write skipped
        run_cmd(1'b1, 1'b1, 8'h00, 8'h00, 32'h2300_0052, "R9");
        // R6: new port and bank needs a bank-select write first
        run_cmd(1'b1, 1'b1, 8'h01, 8'h14, 32'hCAFE_0001, "R6");
        // R5: failed bank-select write leaves the shadow intact
        push_ack(ACK_FAULT);
        run_cmd(1'b0, 1'b1, 8'h00, 8'h08, 32'h0000_0055, "R5");
        run_cmd(1'b1, 1'b0, 8'h01, 8'h14, 32'h0, "R5");
        // R1: WAIT on every attempt exhausts the limit
        for (int i = 0; i < MAX_TRIES; i++) push_ack(ACK_WAIT);
        run_cmd(1'b0, 1'b0, 8'h00, 8'h0C, 32'h0, "R1");
        // R8: failed access write issues no read-buffer read
        push_ack(ACK_FAULT);
        run_cmd(1'b1, 1'b1, 8'h01, 8'h14, 32'h1234_5678, "R8");
        // R8: read buffer fault decides the result
        push_ack(ACK_OK); push_ack(ACK_FAULT);
        run_cmd(1'b1, 1'b1, 8'h01, 8'h18, 32'h0BAD_F00D, "R8");
        // R6: failed bank select aborts the access
        push_ack(ACK_FAULT);
        run_cmd(1'b1, 1'b1, 8'h02, 8'h04, 32'h7777_0000, "R6");
        // R7: first read's fault ignored, second decides
        push_ack(ACK_FAULT); push_ack(ACK_OK);
        run_cmd(1'b1, 1'b0, 8'h01, 8'h1C, 32'h0, "R7");
        // R10: init voids both shadows
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        m_sel = 32'hFFFF_FFFF;
        m_ctl = 32'hFFFF_FFFF;
        run_cmd(1'b0, 1'b1, 8'h00, 8'h08, 32'h0100_0010, "R10");
        run_cmd(1'b1, 1'b1, 8'h00, 8'h00, 32'h2300_0052, "R10");
        run_cmd(1'b1, 1'b1, 8'h00, 8'h00, 32'h2300_0052, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule